// File: doc/BRIEF.md
# Standby Wake-Up Sequencer

This controller puts a small processor core into its deepest low-power state and brings it back out. When the core executes a sleep instruction while the mode-control and I/O-stop bits select standby, the controller drops the oscillator enable and every internal clock enable. It then waits for a wake request on either the interrupt line or the bus-request line. The bus-request line only counts as a wake source when its exit-enable bit is set.

A wake request restarts the oscillator. The controller then counts a stabilization interval on a free-running reference clock, which stays alive while the gated core clocks are off. The request must be held for the whole interval. If it drops at any point, the oscillator is stopped again and standby resumes.

When the count completes, the clocks come back and one of two things happens:
- For an interrupt wake, the interrupt source receives a one-cycle acknowledge.
- For a bus-request wake, the address and strobe pads go tri-state and bus acknowledge is raised. The bus is held off until the external master releases its request.

The interval length is a parameter. Its default is 2^17 reference cycles.

Top module: `standby_wake_seq`

## Requirements
- R1: A synchronous reset (`rst` high) leaves oscEn=1, clkEn=1, busFloat=0, busAck=0 and intAck=0.
- R2: A `sleepStb` pulse enters standby only when modeSel6=1, modeSel3=0 and ioStopEn=1 are all true on that edge. Any other combination leaves the outputs in the running pattern.
- R3: In standby, oscEn=0 and clkEn=0, and busFloat, busAck and intAck are 0.
- R4: A wake request makes oscEn=1 on the next edge. clkEn then stays 0 for exactly STAB_COUNT reference cycles before the clocks return.
- R5: If every wake request drops during stabilization, the next edge returns to standby (oscEn=0, clkEn=0).
- R6: While busExitEn=0, busReq has no effect in standby, and the outputs stay at the standby pattern.
- R7: After an interrupt-only wake completes, intAck=1 with clkEn=1 for exactly one cycle. The block then runs with oscEn=1 and clkEn=1.
- R8: After a bus-request wake completes, clkEn=1, busFloat=1 and busAck=1. This holds for as long as busReq stays high.
- R9: When busReq falls during the bus grant, the next edge gives busAck=0 and busFloat=0 (bus driven), and the clocks stay on.
- R10: If irq and an enabled busReq are both present at completion, the bus is granted first with intAck=0. The interrupt acknowledge follows on the edge after busReq falls, provided irq is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock, active during standby |
| rst | input | 1 | Synchronous reset, active high |
| modeSel6 | input | 1 | Mode-control bit that must be 1 to arm standby |
| modeSel3 | input | 1 | Mode-control bit that must be 0 to arm standby |
| ioStopEn | input | 1 | I/O-stop enable that must be 1 to arm standby |
| sleepStb | input | 1 | One-cycle strobe from sleep instruction execution |
| busExitEn | input | 1 | Allows busReq to wake from standby |
| irq | input | 1 | Interrupt request |
| busReq | input | 1 | External bus request |
| oscEn | output | 1 | Oscillator enable |
| clkEn | output | 1 | Internal clock enables |
| busFloat | output | 1 | Tri-state control for address and strobe pads |
| busAck | output | 1 | Bus acknowledge to the external master |
| intAck | output | 1 | Interrupt acknowledge pulse |

## Verification
The hardest situations to reach are those that hinge on timing relative to the stabilization count. One is a wake request that disappears partway through the interval. The other is an interrupt and an enabled bus request that are both still present at the moment the count completes. The bench builds the block with a short interval so that completion lands at a known edge. It then drops the request a few edges after wake for the abort path. For the second case it holds both sources through completion, checks that the bus is granted with no acknowledge, and releases only the bus request to expose the deferred interrupt acknowledge.

// File: rtl/swk_pkg.sv
package swk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_STANDBY, ST_STABILIZE, ST_INT_ACK, ST_BUS_GRANT, ST_RUN
  } swkState_t;

  typedef struct packed {
    logic oscOn;
    logic clkOn;
    logic busFloat;
    logic busAck;
    logic intAck;
    logic cntClr;
    logic cntInc;
  } swkCtl_t;
endpackage

// File: rtl/swk_datapath.sv
module swk_datapath
  import swk_pkg::*;
#(
  parameter int STAB_COUNT = 131072
) (
  input  logic    clk,
  input  logic    rst,
  input  swkCtl_t ctl,
  output logic    stabDone,
  output logic    oscEn,
  output logic    clkEn,
  output logic    busFloat,
  output logic    busAck,
  output logic    intAck
);
  localparam int CW = (STAB_COUNT > 2) ? $clog2(STAB_COUNT) : 1;
  localparam logic [CW-1:0] LAST = CW'(STAB_COUNT - 1);

  logic [CW-1:0] stabCnt;

  always_ff @(posedge clk) begin
    if (rst || ctl.cntClr) stabCnt <= '0;
    else if (ctl.cntInc && stabCnt != LAST) stabCnt <= stabCnt + 1'b1;
  end

  assign stabDone = ctl.cntInc && (stabCnt == LAST);
  assign oscEn    = ctl.oscOn;
  assign clkEn    = ctl.clkOn;
  assign busFloat = ctl.busFloat;
  assign busAck   = ctl.busAck;
  assign intAck   = ctl.intAck;

  // R7: the acknowledge is a single-cycle pulse
  a_r7_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    intAck |=> !intAck);
  // R4: counter only advances while stabilizing and never wraps past the limit
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    (stabCnt == LAST && ctl.cntInc) |=> (stabCnt == LAST || stabCnt == '0));
endmodule

// File: rtl/swk_ctrl.sv
module swk_ctrl
  import swk_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    modeSel6,
  input  logic    modeSel3,
  input  logic    ioStopEn,
  input  logic    sleepStb,
  input  logic    busExitEn,
  input  logic    irq,
  input  logic    busReq,
  input  logic    stabDone,
  output swkCtl_t ctl
);
  swkState_t state, nextState;
  logic armOk, wakeBus, wakeReq;

  assign armOk   = sleepStb && modeSel6 && !modeSel3 && ioStopEn;
  assign wakeBus = busReq && busExitEn;
  assign wakeReq = irq || wakeBus;

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE, ST_RUN: if (armOk) nextState = ST_STANDBY;
      ST_STANDBY:      if (wakeReq) nextState = ST_STABILIZE;
      ST_STABILIZE: begin
        if (!wakeReq)     nextState = ST_STANDBY;
        else if (stabDone) nextState = wakeBus ? ST_BUS_GRANT : ST_INT_ACK;
      end
      ST_INT_ACK:      nextState = ST_RUN;
      ST_BUS_GRANT:    if (!busReq) nextState = irq ? ST_INT_ACK : ST_RUN;
      default:         nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    ctl = '0;
    case (state)
      ST_STANDBY:   ctl.cntClr = 1'b1;
      ST_STABILIZE: begin ctl.oscOn = 1'b1; ctl.cntInc = 1'b1; end
      ST_INT_ACK:   begin ctl.oscOn = 1'b1; ctl.clkOn = 1'b1; ctl.intAck = 1'b1; end
      ST_BUS_GRANT: begin
        ctl.oscOn = 1'b1; ctl.clkOn = 1'b1; ctl.busFloat = 1'b1; ctl.busAck = 1'b1;
      end
      default:      begin ctl.oscOn = 1'b1; ctl.clkOn = 1'b1; end
    endcase
  end

  // R2: without the full arming condition the core keeps running
  a_r2_no_false_arm: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_IDLE || state == ST_RUN) && !armOk) |=> state != ST_STANDBY);
  // R4: clocks cannot return before the counter reports completion
  a_r4_wait_done: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STABILIZE && !stabDone) |=> (state == ST_STABILIZE || state == ST_STANDBY));
  // R5: losing the wake request during the count aborts back to standby
  a_r5_abort: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STABILIZE && !wakeReq) |=> state == ST_STANDBY);
  // R6: a bus request without its exit enable leaves standby untouched
  a_r6_bus_ignored: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STANDBY && !irq && !busExitEn) |=> state == ST_STANDBY);
  // R9: a released bus request ends the grant on the next edge
  a_r9_release: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BUS_GRANT && !busReq) |=> state != ST_BUS_GRANT);
endmodule

// File: rtl/standby_wake_seq.sv
module standby_wake_seq
  import swk_pkg::*;
#(
  parameter int STAB_COUNT = 131072
) (
  input  logic clk,
  input  logic rst,
  input  logic modeSel6,
  input  logic modeSel3,
  input  logic ioStopEn,
  input  logic sleepStb,
  input  logic busExitEn,
  input  logic irq,
  input  logic busReq,
  output logic oscEn,
  output logic clkEn,
  output logic busFloat,
  output logic busAck,
  output logic intAck
);
  swkCtl_t ctl;
  logic    stabDone;

  swk_ctrl i_ctrl (
    .clk(clk), .rst(rst), .modeSel6(modeSel6), .modeSel3(modeSel3),
    .ioStopEn(ioStopEn), .sleepStb(sleepStb), .busExitEn(busExitEn),
    .irq(irq), .busReq(busReq), .stabDone(stabDone), .ctl(ctl)
  );

  swk_datapath #(.STAB_COUNT(STAB_COUNT)) i_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .stabDone(stabDone),
    .oscEn(oscEn), .clkEn(clkEn), .busFloat(busFloat),
    .busAck(busAck), .intAck(intAck)
  );

  // R8: bus acknowledge always comes with floated pads and running clocks
  a_r8_ack_float: assert property (@(posedge clk) disable iff (rst)
    $rose(busAck) |-> (busFloat && clkEn));
  // R3: the clocks are never on while the oscillator is off
  a_r3_clk_needs_osc: assert property (@(posedge clk) disable iff (rst)
    clkEn |-> oscEn);
endmodule

// File: tb/test_standby_wake_seq.sv
module test_standby_wake_seq;
  localparam int SC = 8;
  localparam logic [4:0] O_RUN  = 5'b11000;
  localparam logic [4:0] O_STBY = 5'b00000;
  localparam logic [4:0] O_STAB = 5'b10000;
  localparam logic [4:0] O_INT  = 5'b11001;
  localparam logic [4:0] O_BUS  = 5'b11110;
  // {modeSel6, modeSel3, ioStopEn, expectStandby}
  localparam logic [3:0] ARM_TBL [8] = '{
    4'b0000, 4'b0010, 4'b0100, 4'b0110, 4'b1000, 4'b1011, 4'b1100, 4'b1110
  };

  logic clk = 1'b0, rst = 1'b1;
  logic modeSel6 = 0, modeSel3 = 0, ioStopEn = 0, sleepStb = 0;
  logic busExitEn = 0, irq = 0, busReq = 0;
  logic oscEn, clkEn, busFloat, busAck, intAck;
  int nChk = 0, nBad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  standby_wake_seq #(.STAB_COUNT(SC)) i_standby_wake_seq (
    .clk(clk), .rst(rst), .modeSel6(modeSel6), .modeSel3(modeSel3),
    .ioStopEn(ioStopEn), .sleepStb(sleepStb), .busExitEn(busExitEn),
    .irq(irq), .busReq(busReq), .oscEn(oscEn), .clkEn(clkEn),
    .busFloat(busFloat), .busAck(busAck), .intAck(intAck)
  );

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [4:0] exp);
    logic [4:0] act;
    act = {oscEn, clkEn, busFloat, busAck, intAck};
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: outputs act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic doReset();
    rst = 1; irq = 0; busReq = 0; busExitEn = 0; sleepStb = 0;
    tick(2);
    rst = 0;
  endtask

  task automatic enterStandby();
    modeSel6 = 1; modeSel3 = 0; ioStopEn = 1; sleepStb = 1;
    tick(1);
    sleepStb = 0;
  endtask

  initial begin
    @(negedge clk);
    doReset();
    chk("R1 reset", O_RUN);

    // R2: arming table
    for (int i = 0; i < 8; i++) begin
      doReset();
      {modeSel6, modeSel3, ioStopEn} = ARM_TBL[i][3:1];
      sleepStb = 1;
      tick(1);
      sleepStb = 0;
      chk("R2 arm", ARM_TBL[i][0] ? O_STBY : O_RUN);
    end

    // R3 standby pattern, R4 count length, R7 interrupt ack
    doReset();
    enterStandby();
    chk("R3 standby", O_STBY);
    irq = 1;
    tick(1);
    chk("R4 osc restart", O_STAB);
    tick(SC - 1);
    chk("R4 clocks still off", O_STAB);
    tick(1);
    chk("R7 int ack", O_INT);
    tick(1);
    chk("R7 running", O_RUN);
    irq = 0;

    // R5 abort
    enterStandby();
    irq = 1;
    tick(4);
    chk("R5 stabilizing", O_STAB);
    irq = 0;
    tick(1);
    chk("R5 abort", O_STBY);

    // R6 bus request ignored without exit enable
    busExitEn = 0; busReq = 1;
    tick(SC + 3);
    chk("R6 ignored", O_STBY);
    busReq = 0;

    // R8 / R9 bus wake
    busExitEn = 1; busReq = 1;
    tick(1);
    chk("R8 osc restart", O_STAB);
    tick(SC);
    chk("R8 grant", O_BUS);
    tick(3);
    chk("R8 grant held", O_BUS);
    busReq = 0;
    tick(1);
    chk("R9 release", O_RUN);

    // R10 both sources
    enterStandby();
    irq = 1; busReq = 1;
    tick(SC + 1);
    chk("R10 bus first", O_BUS);
    busReq = 0;
    tick(1);
    chk("R10 deferred ack", O_INT);
    tick(1);
    chk("R10 running", O_RUN);
    irq = 0;

    // R2: strobe while running without arming bits
    modeSel3 = 1; sleepStb = 1;
    tick(1);
    sleepStb = 0;
    chk("R2 not armed", O_RUN);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule